// File: doc/BRIEF.md
# Stereo Zero-Run Detector

This block watches a stereo PCM stream. Each frame holds one left sample and one right sample, and a one-cycle frame strobe marks it. The block raises a single silence flag once both channels have carried samples that are exactly zero for a long unbroken run of frames. The default run is 8192 frames. Downstream logic can use the flag to gate an output stage or to detect that a source has gone quiet.

The run is counted in frames and not in system clock cycles. Sample values on cycles without a strobe are never looked at. One frame in which either channel is non-zero drops the flag on the next clock edge and starts the run again from nothing. The run count saturates, so a silence of any length keeps the flag high. The reset input is asynchronous and active low. Asserting it forces the flag low at once, and its release is synchronised to the clock inside the block.

Top module: `zero_run_detector`

## Requirements
- R1: After the 8192nd consecutive strobed frame in which both samples equal zero, `zero_flag` reads 1 from the first clock edge that samples that strobe. After only 8191 such frames it still reads 0.
- R2: A strobed frame in which any bit of `left_smp` or `right_smp` is 1 (this includes only bit 0 set, and only bit 23 set) makes `zero_flag` read 0 from the clock edge that samples that strobe.
- R3: Only cycles with `frame_stb` = 1 count as frames. On cycles with `frame_stb` = 0, the sample inputs have no effect on `zero_flag` or on the run, whatever their values.
- R4: The condition is joint. A run of any length in which only one channel is zero never sets `zero_flag`.
- R5: While `rst_n` = 0, `zero_flag` is 0 without waiting for a clock edge. After release, a fresh run of 8192 frames is needed before the flag rises.
- R6: A non-zero frame restarts the run from zero. This holds even when that frame arrives in the position of the 8192nd frame: 8191 further zero frames then still leave the flag at 0, and the next zero frame sets it.
- R7: The run count saturates. The flag stays at 1 through a silence longer than 16384 frames, and a later non-zero frame still clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe marking a valid stereo frame |
| left_smp | input | 24 | Left channel sample, read when strobed |
| right_smp | input | 24 | Right channel sample, read when strobed |
| zero_flag | output | 1 | High while the both-channel silence run has reached its length |

## Verification
Two functions can meet on one strobe: completing the silence run, and restarting it on a non-zero sample. The bench provokes this by sending 8191 zero frames and then a non-zero frame in the slot that would complete the run. It expects the flag to stay low, and it expects exactly 8192 further zero frames to be needed before the flag rises. Checking 8191 frames and then one more shows whether the restart won over the completion, or whether a stale partial count leaked through.

// File: rtl/zdet_pkg.sv
package zdet_pkg;
  localparam int unsigned ZD_CHANNELS = 2;
  localparam int unsigned ZD_LEFT     = 0;
  localparam int unsigned ZD_RIGHT    = 1;

  function automatic int unsigned zd_cnt_width(input int unsigned run_len);
    return $clog2(run_len + 1);
  endfunction
endpackage

// File: rtl/zdet_rst_sync.sv
module zdet_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/zdet_chan_cmp.sv
module zdet_chan_cmp #(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0] smp,
  output logic                is_zero
);
  always_comb is_zero = (smp == '0);
endmodule

// File: rtl/zdet_run_cnt.sv
module zdet_run_cnt #(
  parameter int unsigned RUN_LEN = 8192,
  parameter int unsigned CNT_W   = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic all_zero,
  output logic full_nxt
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (stb) begin
      if (!all_zero)           cnt_d = '0;
      else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign full_nxt = (cnt_d == LIMIT);
endmodule

// File: rtl/zdet_flag_reg.sv
module zdet_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic full_nxt,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (stb) flag_d = full_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/zero_run_detector.sv
module zero_run_detector #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned RUN_LEN  = 8192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_stb,
  input  logic [SAMPLE_W-1:0] left_smp,
  input  logic [SAMPLE_W-1:0] right_smp,
  output logic                zero_flag
);
  import zdet_pkg::*;

  localparam int unsigned CNT_W = zd_cnt_width(RUN_LEN);

  logic                                  rst_int_n;
  logic [ZD_CHANNELS-1:0][SAMPLE_W-1:0]  smp_vec;
  logic [ZD_CHANNELS-1:0]                ch_zero;
  logic                                  all_zero;
  logic                                  full_nxt;
  logic                                  flag_int;

  assign smp_vec[ZD_LEFT]  = left_smp;
  assign smp_vec[ZD_RIGHT] = right_smp;

  zdet_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar ch = 0; ch < ZD_CHANNELS; ch++) begin : g_chan
    zdet_chan_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
      .smp     (smp_vec[ch]),
      .is_zero (ch_zero[ch])
    );
  end

  assign all_zero = &ch_zero;

  zdet_run_cnt #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_run_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .stb      (frame_stb),
    .all_zero (all_zero),
    .full_nxt (full_nxt)
  );

  zdet_flag_reg u_flag (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .stb      (frame_stb),
    .full_nxt (full_nxt),
    .flag     (flag_int)
  );

  assign zero_flag = flag_int;
endmodule

// File: rtl/zdet_chk.sv
module zdet_chk #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned RUN_LEN  = 8192
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_stb,
  input logic [SAMPLE_W-1:0] left_smp,
  input logic [SAMPLE_W-1:0] right_smp,
  input logic                zero_flag
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] CHK_LIM = CW'(RUN_LEN);

  logic [CW-1:0] chk_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_run <= '0;
    else if (frame_stb) begin
      if (left_smp != '0 || right_smp != '0) chk_run <= '0;
      else if (chk_run != CHK_LIM)           chk_run <= chk_run + 1'b1;
    end
  end

  // R1
  flag_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_flag |-> (chk_run == CHK_LIM));

  // R1
  rise_on_zero_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_flag) |-> $past(frame_stb && left_smp == '0 && right_smp == '0));

  // R2
  nonzero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && (left_smp != '0 || right_smp != '0)) |=> !zero_flag);

  // R3
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(zero_flag));

  // R5
  always @(posedge clk) begin
    if (rst_n === 1'b0) reset_low_chk: assert (zero_flag == 1'b0);
  end
endmodule

bind zero_run_detector zdet_chk #(.SAMPLE_W(SAMPLE_W), .RUN_LEN(RUN_LEN)) u_zdet_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_stb (frame_stb),
  .left_smp  (left_smp),
  .right_smp (right_smp),
  .zero_flag (zero_flag)
);

// File: tb/zero_run_detector_test.sv
`timescale 1ns/1ps
module zero_run_detector_test;
  localparam int RUN = 8192;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_stb;
  logic [23:0] left_smp, right_smp;
  logic        zero_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  zero_run_detector uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .left_smp  (left_smp),
    .right_smp (right_smp),
    .zero_flag (zero_flag)
  );

  task automatic check(input string req, input logic exp);
    n_tests++;
    if (zero_flag !== exp) begin
      n_fail++;
      $display("FAIL %s: zero_flag=%b expected=%b", req, zero_flag, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; frame_stb = 1'b0; left_smp = '0; right_smp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // one strobed frame; with gap, a non-strobed cycle carrying junk follows
  task automatic send_frame(input logic [23:0] l, input logic [23:0] r, input bit gap);
    @(negedge clk);
    frame_stb = 1'b1; left_smp = l; right_smp = r;
    if (gap) begin
      @(negedge clk);
      frame_stb = 1'b0; left_smp = 24'hABCDEF; right_smp = 24'h123456;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_stb = 1'b0; left_smp = 24'h00F00D; right_smp = 24'h800001;
    end
  endtask

  task automatic send_zeros(input int n, input bit gap);
    for (int i = 0; i < n; i++) send_frame('0, '0, gap);
    if (!gap) idle(1);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R5 flag low after reset", 1'b0);
  endtask

  task automatic t_rise_and_idle();
    send_zeros(RUN - 1, 1'b1);
    check("R1 flag low after 8191 zero frames", 1'b0);
    send_zeros(1, 1'b1);
    check("R1 flag high after 8192 zero frames", 1'b1);
    idle(6);
    check("R3 junk without strobe keeps flag", 1'b1);
  endtask

  task automatic t_clear();
    send_frame(24'h000001, '0, 1'b1);
    check("R2 left bit0 clears flag", 1'b0);
    send_zeros(RUN, 1'b0);
    check("R1 flag high again after full run", 1'b1);
    send_frame('0, 24'h800000, 1'b1);
    check("R2 right bit23 clears flag", 1'b0);
  endtask

  task automatic t_coincide();
    send_zeros(RUN - 1, 1'b0);
    send_frame('0, 24'h000005, 1'b1);
    check("R6 nonzero in completing slot keeps flag low", 1'b0);
    send_zeros(RUN - 1, 1'b0);
    check("R6 run restarted, 8191 not enough", 1'b0);
    send_zeros(1, 1'b0);
    check("R6 flag high after fresh 8192", 1'b1);
  endtask

  task automatic t_one_channel();
    do_reset();
    for (int i = 0; i < RUN + 50; i++) send_frame('0, 24'h000007, 1'b0);
    idle(1);
    check("R4 only left silent never sets", 1'b0);
    for (int i = 0; i < RUN + 50; i++) send_frame(24'h000003, '0, 1'b0);
    idle(1);
    check("R4 only right silent never sets", 1'b0);
  endtask

  task automatic t_saturate();
    send_zeros(RUN, 1'b0);
    check("R7 flag high at run end", 1'b1);
    for (int k = 0; k < 9; k++) begin
      send_zeros(1000, 1'b0);
      check("R7 flag stays high in long silence", 1'b1);
    end
    send_frame(24'h400000, 24'h000001, 1'b1);
    check("R7 nonzero clears after saturation", 1'b0);
  endtask

  task automatic t_reset_mid();
    send_zeros(RUN, 1'b0);
    check("R5 flag high before mid reset", 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check("R5 flag low immediately on reset", 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send_zeros(RUN - 1, 1'b0);
    check("R5 run cleared by reset", 1'b0);
    send_zeros(1, 1'b0);
    check("R5 flag rises after fresh run", 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; frame_stb = 1'b0; left_smp = '0; right_smp = '0;
    t_reset_state();
    t_rise_and_idle();
    t_clear();
    t_coincide();
    t_one_channel();
    t_saturate();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule